// File: doc/BRIEF.md
# Pin-Level I2C Target Bridge

This block sits between two I2C line levels coming from a host and a transaction-level model of a target device. It watches the clock and data lines, which arrive already synchronised to the system clock. From their transitions it recovers bus conditions, address bytes, written bytes and read cycles. It reports each one to the target model as a single-cycle event pulse.

The block also takes part in the bus. It drives the acknowledge bit low and shifts read data out on the data line. The level it reports is the wired-AND of its own drive and the host's last data level. A separate notify output toggles each time that resolved level changes, so a consumer can follow it without comparing values.

All protocol work happens on a rising edge of the bus clock: sampling, driving the acknowledge and driving each read bit. A falling edge of the bus clock only releases the block's drive. A read byte is fetched from the target at the first bit clock of that byte, not in advance. When the host refuses a read byte, the block stays passive until the next STOP.

Top module: `i2c_pin_bridge`

## Requirements
- R1: After reset the resolved data output is 1, the notify output is 0, no event is asserted, and the block is idle.
- R2: A data-line fall while the stored clock level is high is a START. The block begins shifting a new byte, and that byte is treated as an address byte. This holds as a repeated START in the middle of a transfer.
- R3: A data-line rise while the stored clock level is high is a STOP. The STOP pulses `ev_end` only if an address byte was accepted since the last START, and it returns the block to idle.
- R4: A data-line change while the clock is low only updates the stored host level. It produces no event. Re-applying an unchanged level has no effect.
- R5: A bus-clock falling edge releases the block's drive: the drive goes to 1 in the cycle that follows.
- R6: In idle, and in the parked state entered after a host NACK, bus-clock rising edges produce no event and leave the drive released.
- R7: Eight rising edges shift the host data bit into a byte, MSB first. On the ninth rising edge, the first byte after START pulses `ev_start` with `ev_addr` = byte[7:1] and `ev_rd` = byte[0], and the block drives the data line low.
- R8: On that ninth edge, any byte after the address pulses `ev_wr` with `ev_wdata` = byte, and the block drives the data line low. After an acknowledge, the transfer continues with reading if the address byte's bit 0 is 1, otherwise with writing.
- R9: On the first read-bit rising edge, `ev_rdreq` pulses and `rd_byte` is taken in that same cycle. On that edge and the next seven, the block drives the byte's bits MSB first.
- R10: The rising edge after eight read bits samples the host acknowledge. A 0 starts another read byte with a new `ev_rdreq`. A 1 pulses `ev_nack` and parks the block until STOP.
- R11: `sda_res` equals the block's drive ANDed with the stored host data level.
- R12: `sda_chg` toggles one cycle after `sda_res` takes a value different from its previous one, and at no other time.
- R13: If both lines change in the same cycle, the data change is judged against the old clock level first. The clock edge then uses the new data level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Synchronised bus clock level from the host |
| sda_in | input | 1 | Synchronised bus data level from the host |
| rd_byte | input | BYTE_W | Read data from the target, valid while `ev_rdreq` is high |
| ev_start | output | 1 | Address byte accepted (pulse) |
| ev_addr | output | BYTE_W-1 | Target address, valid with `ev_start` |
| ev_rd | output | 1 | Read flag, valid with `ev_start` |
| ev_wr | output | 1 | Data byte written by the host (pulse) |
| ev_wdata | output | BYTE_W | Written byte, valid with `ev_wr` |
| ev_rdreq | output | 1 | Request for the next read byte (pulse) |
| ev_nack | output | 1 | Host refused a read byte (pulse) |
| ev_end | output | 1 | STOP ended an addressed transfer (pulse) |
| sda_res | output | 1 | Resolved data line level |
| sda_chg | output | 1 | Toggles whenever `sda_res` changes |

## Verification
The assertions check the following on every cycle:
- the drive releases after each clock fall;
- a low host data level reaches the resolved output one cycle later;
- the acknowledge is driven low after an address or write event;
- at most one event pulses at a time;
- read requests appear only on a clock rise;
- the notify output follows changes of the resolved level exactly.

Only the bench's scenarios can show the rest:
- that bytes are assembled MSB first and reported with the right address and read flag;
- that read bytes reach the line in the right order;
- that a NACK parks the block until STOP;
- that STOP without an accepted address stays silent;
- how simultaneous line changes are ordered.

// File: rtl/i2cb_pkg.sv
package i2cb_pkg;

    localparam int LINE_N  = 2;
    localparam int IDX_SDA = 0;
    localparam int IDX_SCL = 1;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_WBIT,
        PH_WACK,
        PH_RBIT,
        PH_RACK,
        PH_PARK
    } phase_e;

    typedef struct packed {
        logic start;
        logic wr;
        logic rdreq;
        logic nack;
        logic fin;
    } evt_s;

    // Phase entered after an acknowledge, chosen by the direction flag.
    function automatic phase_e after_ack(input logic rd_flag);
        return rd_flag ? PH_RBIT : PH_WBIT;
    endfunction

endpackage

// File: rtl/i2cb_line.sv
module i2cb_line (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    output logic q,
    output logic rise,
    output logic fall
);
    always_ff @(posedge clk) begin
        if (rst) q <= 1'b1;
        else     q <= lvl;
    end

    assign rise = lvl & ~q;
    assign fall = ~lvl & q;
endmodule

// File: rtl/i2cb_core.sv
module i2cb_core
    import i2cb_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_old,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_new,
    input  logic              sda_rise,
    input  logic              sda_fall,
    input  logic [BYTE_W-1:0] rd_byte,
    output evt_s              evt,
    output logic [BYTE_W-1:0] byte_out,
    output logic              drv
);
    localparam int CNT_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

    phase_e            ph, ph_n;
    logic [CNT_W-1:0]  cnt, cnt_n;
    logic [BYTE_W-1:0] sh, sh_n;
    logic [BYTE_W-1:0] ab, ab_n;
    logic              av, av_n;
    logic              drv_n;
    logic [BYTE_W-1:0] cur;
    logic              rd_flag;

    always_comb begin
        ph_n    = ph;
        cnt_n   = cnt;
        sh_n    = sh;
        ab_n    = ab;
        av_n    = av;
        drv_n   = drv;
        evt     = '0;
        cur     = sh;
        rd_flag = ab[0];

        // Bus conditions judged against the previous clock level.
        if (scl_old && sda_fall) begin
            ph_n  = PH_WBIT;
            cnt_n = '0;
            av_n  = 1'b0;
            drv_n = 1'b1;
        end else if (scl_old && sda_rise) begin
            evt.fin = av;
            av_n    = 1'b0;
            ph_n    = PH_IDLE;
            drv_n   = 1'b1;
        end

        if (scl_fall) begin
            drv_n = 1'b1;
        end else if (scl_rise) begin
            case (ph)
                PH_IDLE, PH_PARK: drv_n = 1'b1;
                PH_WBIT: begin
                    sh_n  = {sh[BYTE_W-2:0], sda_new};
                    drv_n = 1'b1;
                    if (cnt == CNT_LAST) begin
                        ph_n  = PH_WACK;
                        cnt_n = '0;
                    end else begin
                        cnt_n = cnt + 1'b1;
                    end
                end
                PH_WACK: begin
                    drv_n = 1'b0;
                    if (!av) begin
                        av_n      = 1'b1;
                        ab_n      = sh;
                        evt.start = 1'b1;
                        rd_flag   = sh[0];
                    end else begin
                        evt.wr = 1'b1;
                    end
                    ph_n  = after_ack(rd_flag);
                    cnt_n = '0;
                end
                PH_RBIT: begin
                    if (cnt == '0) begin
                        cur       = rd_byte;
                        evt.rdreq = 1'b1;
                    end
                    drv_n = cur[BYTE_W-1];
                    sh_n  = cur << 1;
                    if (cnt == CNT_LAST) begin
                        ph_n  = PH_RACK;
                        cnt_n = '0;
                    end else begin
                        cnt_n = cnt + 1'b1;
                    end
                end
                PH_RACK: begin
                    drv_n = 1'b1;
                    cnt_n = '0;
                    if (sda_new) begin
                        evt.nack = 1'b1;
                        ph_n     = PH_PARK;
                    end else begin
                        ph_n = PH_RBIT;
                    end
                end
                default: ph_n = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph  <= PH_IDLE;
            cnt <= '0;
            sh  <= '0;
            ab  <= '0;
            av  <= 1'b0;
            drv <= 1'b1;
        end else begin
            ph  <= ph_n;
            cnt <= cnt_n;
            sh  <= sh_n;
            ab  <= ab_n;
            av  <= av_n;
            drv <= drv_n;
        end
    end

    assign byte_out = sh;
endmodule

// File: rtl/i2cb_notify.sv
module i2cb_notify (
    input  logic clk,
    input  logic rst,
    input  logic drv,
    input  logic host_lvl,
    output logic res,
    output logic chg
);
    logic res_q;

    assign res = drv & host_lvl;

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= 1'b1;
            chg   <= 1'b0;
        end else if (res != res_q) begin
            res_q <= res;
            chg   <= ~chg;
        end
    end
endmodule

// File: rtl/i2c_pin_bridge.sv
module i2c_pin_bridge
    import i2cb_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic [BYTE_W-1:0] rd_byte,
    output logic              ev_start,
    output logic [BYTE_W-2:0] ev_addr,
    output logic              ev_rd,
    output logic              ev_wr,
    output logic [BYTE_W-1:0] ev_wdata,
    output logic              ev_rdreq,
    output logic              ev_nack,
    output logic              ev_end,
    output logic              sda_res,
    output logic              sda_chg
);
    logic [LINE_N-1:0] pin_in, pin_q, pin_rise, pin_fall;
    logic              scl_q, sda_q, drv;
    evt_s              evt;
    logic [BYTE_W-1:0] byte_v;

    assign pin_in[IDX_SCL] = scl_in;
    assign pin_in[IDX_SDA] = sda_in;

    for (genvar g = 0; g < LINE_N; g++) begin : g_line
        i2cb_line u_line (
            .clk  (clk),
            .rst  (rst),
            .lvl  (pin_in[g]),
            .q    (pin_q[g]),
            .rise (pin_rise[g]),
            .fall (pin_fall[g])
        );
    end

    assign scl_q = pin_q[IDX_SCL];
    assign sda_q = pin_q[IDX_SDA];

    i2cb_core #(.BYTE_W(BYTE_W)) u_core (
        .clk      (clk),
        .rst      (rst),
        .scl_old  (scl_q),
        .scl_rise (pin_rise[IDX_SCL]),
        .scl_fall (pin_fall[IDX_SCL]),
        .sda_new  (sda_in),
        .sda_rise (pin_rise[IDX_SDA]),
        .sda_fall (pin_fall[IDX_SDA]),
        .rd_byte  (rd_byte),
        .evt      (evt),
        .byte_out (byte_v),
        .drv      (drv)
    );

    i2cb_notify u_notify (
        .clk      (clk),
        .rst      (rst),
        .drv      (drv),
        .host_lvl (sda_q),
        .res      (sda_res),
        .chg      (sda_chg)
    );

    assign ev_start = evt.start;
    assign ev_wr    = evt.wr;
    assign ev_rdreq = evt.rdreq;
    assign ev_nack  = evt.nack;
    assign ev_end   = evt.fin;
    assign ev_addr  = byte_v[BYTE_W-1:1];
    assign ev_rd    = byte_v[0];
    assign ev_wdata = byte_v;
endmodule

// File: rtl/i2cb_chk.sv
module i2cb_chk (
    input logic clk,
    input logic rst,
    input logic scl_in,
    input logic sda_in,
    input logic scl_q,
    input logic drv,
    input logic ev_start,
    input logic ev_wr,
    input logic ev_rdreq,
    input logic ev_nack,
    input logic ev_end,
    input logic sda_res,
    input logic sda_chg
);
    p_release_fall_r5: assert property (@(posedge clk) disable iff (rst)
        (scl_q && !scl_in) |=> drv);

    p_host_low_r11: assert property (@(posedge clk) disable iff (rst)
        !sda_in |=> !sda_res);

    p_one_event_r7: assert property (@(posedge clk) disable iff (rst)
        $countones({ev_start, ev_wr, ev_rdreq, ev_nack, ev_end}) <= 1);

    p_ack_low_r8: assert property (@(posedge clk) disable iff (rst)
        (ev_start || ev_wr) |=> !drv);

    p_rdreq_rise_r9: assert property (@(posedge clk) disable iff (rst)
        ev_rdreq |-> (scl_in && !scl_q));

    p_notify_flip_r12: assert property (@(posedge clk) disable iff (rst)
        (sda_res != $past(sda_res)) |=> (sda_chg != $past(sda_chg)));

    p_notify_hold_r12: assert property (@(posedge clk) disable iff (rst)
        (sda_res == $past(sda_res)) |=> $stable(sda_chg));
endmodule

bind i2c_pin_bridge i2cb_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .scl_in   (scl_in),
    .sda_in   (sda_in),
    .scl_q    (scl_q),
    .drv      (drv),
    .ev_start (ev_start),
    .ev_wr    (ev_wr),
    .ev_rdreq (ev_rdreq),
    .ev_nack  (ev_nack),
    .ev_end   (ev_end),
    .sda_res  (sda_res),
    .sda_chg  (sda_chg)
);

// File: tb/i2c_pin_bridge_tb_top.sv
module i2c_pin_bridge_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_in = 1'b1;
    logic       sda_in = 1'b1;
    logic [7:0] rd_byte = 8'hFF;
    logic       ev_start, ev_rd, ev_wr, ev_rdreq, ev_nack, ev_end, sda_res, sda_chg;
    logic [6:0] ev_addr;
    logic [7:0] ev_wdata;

    i2c_pin_bridge dut_i (
        .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in), .rd_byte(rd_byte),
        .ev_start(ev_start), .ev_addr(ev_addr), .ev_rd(ev_rd), .ev_wr(ev_wr),
        .ev_wdata(ev_wdata), .ev_rdreq(ev_rdreq), .ev_nack(ev_nack), .ev_end(ev_end),
        .sda_res(sda_res), .sda_chg(sda_chg)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int tests = 0;
    int fails = 0;
    int n_start = 0, n_wr = 0, n_rdreq = 0, n_nack = 0, n_end = 0;
    logic last_res;
    int   rq[$];

    // behavioural reference state
    int m_ph = 0;        // 0 idle,1 write bits,2 ack,3 read bits,4 host ack,5 parked
    int m_n = 0;
    int m_byte = 0;
    int m_addr = 0;
    int m_rb = 0;
    bit m_have = 0;
    bit m_drv = 1, m_sda = 1, m_scl = 1, m_prev = 1, m_tgl = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input bit c, input bit s);
        bit e_start, e_wr, e_rdreq, e_nack, e_end, exp_res;
        int e_addr, e_rd, e_wd;
        @(negedge clk);
        scl_in  = c;
        sda_in  = s;
        rd_byte = (rq.size() > 0) ? rq[0][7:0] : 8'hFF;
        #1;
        exp_res = m_drv & m_sda;
        last_res = sda_res;
        chk(sda_res == exp_res, "R11 resolved level", sda_res, exp_res);
        chk(sda_chg == m_tgl, "R12 notify", sda_chg, m_tgl);
        {e_start, e_wr, e_rdreq, e_nack, e_end} = '0;
        e_addr = 0; e_rd = 0; e_wd = 0;
        if (s != m_sda && m_scl) begin       // R13: old clock level decides
            if (!s) begin m_ph = 1; m_n = 0; m_have = 0; m_drv = 1; end
            else begin e_end = m_have; m_have = 0; m_ph = 0; m_drv = 1; end
        end
        m_sda = s;
        if (c != m_scl) begin
            m_scl = c;
            if (!c) m_drv = 1;
            else begin
                case (m_ph)
                    1: begin
                        m_byte = ((m_byte << 1) | s) & 255;
                        m_n++;
                        m_drv = 1;
                        if (m_n == 8) m_ph = 2;
                    end
                    2: begin
                        m_drv = 0;
                        if (!m_have) begin
                            e_start = 1; e_addr = m_byte >> 1; e_rd = m_byte & 1;
                            m_have = 1; m_addr = m_byte;
                        end else begin
                            e_wr = 1; e_wd = m_byte;
                        end
                        m_ph = (m_addr & 1) ? 3 : 1;
                        m_n = 0;
                    end
                    3: begin
                        if (m_n == 0) begin
                            e_rdreq = 1;
                            m_rb = (rq.size() > 0) ? rq.pop_front() : 255;
                        end
                        m_drv = (m_rb >> (7 - m_n)) & 1;
                        m_n++;
                        if (m_n == 8) m_ph = 4;
                    end
                    4: begin
                        m_drv = 1;
                        m_n = 0;
                        if (s) begin e_nack = 1; m_ph = 5; end
                        else m_ph = 3;
                    end
                    default: m_drv = 1;
                endcase
            end
        end
        chk(ev_start == e_start, "R7 start event", ev_start, e_start);
        if (e_start) begin
            chk(ev_addr == e_addr[6:0], "R7 address", ev_addr, e_addr);
            chk(ev_rd == e_rd[0], "R7 read flag", ev_rd, e_rd);
        end
        chk(ev_wr == e_wr, "R8 write event", ev_wr, e_wr);
        if (e_wr) chk(ev_wdata == e_wd[7:0], "R8 write data", ev_wdata, e_wd);
        chk(ev_rdreq == e_rdreq, "R9 read request", ev_rdreq, e_rdreq);
        chk(ev_nack == e_nack, "R10 nack event", ev_nack, e_nack);
        chk(ev_end == e_end, "R3 end event", ev_end, e_end);
        n_start += ev_start; n_wr += ev_wr; n_rdreq += ev_rdreq;
        n_nack += ev_nack; n_end += ev_end;
        if (exp_res != m_prev) begin m_prev = exp_res; m_tgl = ~m_tgl; end
    endtask

    task automatic clr_counts();
        n_start = 0; n_wr = 0; n_rdreq = 0; n_nack = 0; n_end = 0;
    endtask

    task automatic hstart();
        step(0, 1); step(1, 1); step(1, 0); step(0, 0);
    endtask

    task automatic hstop();
        step(0, 0); step(1, 0); step(1, 1);
    endtask

    task automatic hbit(input bit b, output bit seen);
        step(0, b); step(1, b); step(1, b);
        seen = last_res;
        step(0, b);
    endtask

    task automatic hbyte(input int v, output int seen);
        bit r;
        seen = 0;
        for (int i = 7; i >= 0; i--) begin
            hbit(v[i], r);
            seen = (seen << 1) | r;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int  got;
        bit  ack;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state
        chk(sda_res == 1'b1, "R1 reset resolved", sda_res, 1);
        chk(sda_chg == 1'b0, "R1 reset notify", sda_chg, 0);
        chk({ev_start, ev_wr, ev_rdreq, ev_nack, ev_end} == 5'b0, "R1 reset events",
            {ev_start, ev_wr, ev_rdreq, ev_nack, ev_end}, 0);

        // R6: idle clocks do nothing; R4: data moves while clock low
        clr_counts();
        for (int i = 0; i < 3; i++) begin step(0, 1); step(0, 0); step(0, 1); step(1, 1); end
        chk(n_start + n_wr + n_rdreq + n_nack + n_end == 0, "R6 idle quiet",
            n_start + n_wr + n_rdreq + n_nack + n_end, 0);

        // R2 R7 R8 R3: write transfer to address 0x50
        clr_counts();
        hstart();
        hbyte(8'hA0, got); hbit(1, ack);
        chk(ack == 1'b0, "R7 address acked", ack, 0);
        hbyte(8'h3C, got); hbit(1, ack);
        chk(ack == 1'b0, "R8 data acked", ack, 0);
        hbyte(8'hC5, got); hbit(1, ack);
        hstop();
        chk(n_start == 1 && n_wr == 2 && n_end == 1, "R8 write counts",
            n_start * 100 + n_wr * 10 + n_end, 121);

        // R9 R10: read from address 0x51, two bytes, NACK on the second
        clr_counts();
        rq.push_back(8'h96); rq.push_back(8'h5A);
        hstart();
        hbyte(8'hA3, got); hbit(1, ack);
        hbyte(8'hFF, got); hbit(0, ack);
        chk(got == 8'h96, "R9 first read byte", got, 8'h96);
        hbyte(8'hFF, got); hbit(1, ack);
        chk(got == 8'h5A, "R9 second read byte", got, 8'h5A);
        chk(n_rdreq == 2 && n_nack == 1, "R10 read counts", n_rdreq * 10 + n_nack, 21);
        // R6 parked: further clocks are quiet
        clr_counts();
        hbyte(8'hFF, got);
        chk(got == 8'hFF && n_rdreq == 0, "R6 parked quiet", got, 8'hFF);
        hstop();
        chk(n_end == 1, "R3 end after parked", n_end, 1);

        // R3: STOP with no address accepted stays silent
        clr_counts();
        hstart();
        hstop();
        chk(n_end == 0, "R3 no address no end", n_end, 0);

        // R13: both lines fall together from idle -> START, then bits with simultaneous rise
        clr_counts();
        step(0, 0);
        for (int i = 7; i >= 0; i--) begin
            step(1, 8'h6E >> i & 1); step(1, 8'h6E >> i & 1); step(0, 8'h6E >> i & 1);
        end
        step(1, 1); step(0, 1);
        chk(n_start == 1, "R13 simultaneous start", n_start, 1);
        // R2: repeated START mid-transfer gives a fresh address
        hstart();
        hbyte(8'h22, got); hbit(1, ack);
        chk(n_start == 2, "R2 repeated start", n_start, 2);
        hstop();
        chk(n_end == 1, "R3 end once", n_end, 1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule